// File: doc/BRIEF.md
# Pixel-Framed Serial Video Transmitter

This block turns one parallel video word per pixel period into a serial bit stream on one, two or three data lanes. Each word has 30 bits: 24 colour bits, the three timing flags, two general-purpose bits and an even-parity bit. Every enabled cycle of the fast clock is one serial bit slot. A pixel strobe marks the pixel-clock edge.

On each strobe the block captures the present pixel into a holding register. In the same cycle the shifter takes the word captured at the previous strobe. The first bit of that word goes out in the slot that follows the strobe, and a reference output marks this slot, so the receiver can find bit 1 of the word. No line coding is used and no clock is embedded: the strobe and the bit enable stand for the pixel clock and the bit clock that a clock generator outside the block would supply.

Top module: `pxser_tx`

## Requirements
- R1: Word layout, most significant bit sent first: bits 29..22 red, 21..14 green, 13..6 blue, 5 hsync, 4 vsync, 3 den, 2..1 gp, 0 parity.
- R2: Bit 0 makes the XOR of all 30 word bits zero (even parity over the other 29 bits).
- R3: Serial bit k (k = 0 is sent first) goes out on lane k mod N in slot k div N. The lane count N comes from lanes_sel: 0 or 1 selects one lane, 2 selects two lanes, 3 selects three lanes.
- R4: The colour, flag and gp inputs are sampled only on strobe cycles (bit_en and px_stb both high). The word sampled at one strobe is transmitted starting after the next strobe.
- R5: px_ref is high in the first bit slot after a strobe and low in every other slot.
- R6: lanes_sel is sampled only on a strobe cycle. A change between strobes does not affect the word in flight.
- R7: Lanes at or above the active lane count stay low. Once all 30 bits have been sent, every lane stays low until the next strobe.
- R8: A cycle with bit_en low leaves lane_dat and px_ref unchanged.
- R9: While rst_n is low (synchronous reset), lane_dat and px_ref are low and the holding register is cleared. The first word sent after reset is therefore all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Bit-slot enable |
| px_stb | input | 1 | Pixel boundary strobe, qualified by bit_en |
| lanes_sel | input | 2 | Lane count select |
| red | input | 8 | Red component |
| grn | input | 8 | Green component |
| blu | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| den | input | 1 | Data enable |
| gp | input | 2 | General-purpose bits |
| lane_dat | output | 3 | Serial data, one bit per lane |
| px_ref | output | 1 | Marks the first bit slot of a word |

## Verification
The assertions check on every cycle that unused lanes stay low, that a disabled cycle freezes the outputs, that the reference marker appears exactly once per word, and that reset clears the outputs. The bench scenarios cover the word content, which a single-cycle property cannot show: field order, parity, round-robin dealing across lanes, the one-pixel latency through the holding register, and lane-count changes that arrive mid-pixel.

// File: rtl/pxser_tx.sv
module pxser_tx #(
  parameter int CW  = 8,
  parameter int GPW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bit_en,
  input  logic           px_stb,
  input  logic [1:0]     lanes_sel,
  input  logic [CW-1:0]  red,
  input  logic [CW-1:0]  grn,
  input  logic [CW-1:0]  blu,
  input  logic           hsync,
  input  logic           vsync,
  input  logic           den,
  input  logic [GPW-1:0] gp,
  output logic [2:0]     lane_dat,
  output logic           px_ref
);
  localparam int W    = 3*CW + 3 + GPW + 1;
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    hold_q, sh_q;
  logic [1:0]      nl_q;
  logic [CNTW-1:0] slot_q;

  wire           strobe = bit_en & px_stb;
  wire [W-2:0]   body   = {red, grn, blu, hsync, vsync, den, gp};
  wire [W-1:0]   word   = {body, ^body};
  wire [1:0]     nl_in  = (lanes_sel == 2'd0) ? 2'd1 : lanes_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      nl_q   <= 2'd1;
      slot_q <= CNTW'(W);
    end else if (strobe) begin
      hold_q <= word;
      sh_q   <= hold_q;
      nl_q   <= nl_in;
      slot_q <= '0;
    end else if (bit_en) begin
      case (nl_q)
        2'd3:    sh_q <= sh_q << 3;
        2'd2:    sh_q <= sh_q << 2;
        default: sh_q <= sh_q << 1;
      endcase
      if (slot_q < CNTW'(W)) slot_q <= slot_q + 1'b1;
    end
  end

  assign lane_dat[0] = sh_q[W-1];
  assign lane_dat[1] = (nl_q >= 2'd2) ? sh_q[W-2] : 1'b0;
  assign lane_dat[2] = (nl_q == 2'd3) ? sh_q[W-3] : 1'b0;
  assign px_ref      = (slot_q == '0);
endmodule

// File: rtl/pxser_tx_chk.sv
module pxser_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_en,
  input logic       px_stb,
  input logic [1:0] lanes_sel,
  input logic [2:0] lane_dat,
  input logic       px_ref
);
  logic [1:0] n_q;
  always_ff @(posedge clk) begin
    if (!rst_n) n_q <= 2'd1;
    else if (bit_en && px_stb) n_q <= (lanes_sel == 2'd0) ? 2'd1 : lanes_sel;
  end

  p_lane2_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q != 2'd3) |-> !lane_dat[2]);
  p_lane1_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (n_q == 2'd1) |-> !lane_dat[1]);
  p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(lane_dat) && $stable(px_ref)));
  p_ref_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && px_stb) |=> px_ref);
  p_ref_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (px_ref && bit_en && !px_stb) |=> !px_ref);
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (lane_dat == 3'b000 && !px_ref));
endmodule

bind pxser_tx pxser_tx_chk u_chk (.*);

// File: tb/sim_pxser_tx.sv
module sim_pxser_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0, bit_en = 1'b0, px_stb = 1'b0;
  logic [1:0] lanes_sel = 2'd1;
  logic [7:0] red = '0, grn = '0, blu = '0;
  logic       hsync = 1'b0, vsync = 1'b0, den = 1'b0;
  logic [1:0] gp = '0;
  logic [2:0] lane_dat;
  logic       px_ref;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [29:0] prev_word = '0;

  always #10 clk = ~clk;

  pxser_tx u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .px_stb(px_stb),
    .lanes_sel(lanes_sel), .red(red), .grn(grn), .blu(blu), .hsync(hsync),
    .vsync(vsync), .den(den), .gp(gp), .lane_dat(lane_dat), .px_ref(px_ref));

  // {lanes_sel[1:0], red, grn, blu, hsync, vsync, den, gp[1:0]}
  localparam logic [30:0] VEC [8] = '{
    31'h2123_4567, 31'h5FED_CBA9, 31'h7A5A_5A5A, 31'h0F0F_00FF,
    31'h6000_0001, 31'h3FFF_FFFF, 31'h4C3C_3C3D, 31'h2000_0000 };

  function automatic logic [29:0] mkword(input logic [28:0] b);
    return {b, ^b};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic drive_body(input logic [28:0] b);
    {red, grn, blu, hsync, vsync, den, gp} = b;
  endtask

  // One pixel period: strobe, then slots; checks the previous word on the lanes
  task automatic run_px(input logic [1:0] sel, input logic [28:0] b, input int extra, input int stall_at);
    int n = (sel == 2'd0) ? 1 : int'(sel);
    int slots = 30 / n + extra;
    logic [29:0] rebuilt = '0;
    for (int c = 0; c < slots; c++) begin
      if (c == stall_at) begin
        logic [2:0] keep_d = lane_dat;
        logic keep_r = px_ref;
        for (int s = 0; s < 3; s++) begin
          @(negedge clk); bit_en = 1'b0; px_stb = 1'b0; drive_body(~b);
          @(posedge clk); #2;
          check(lane_dat == keep_d && px_ref == keep_r, "R8 stall changed outputs",
                {28'd0, px_ref, lane_dat}, {28'd0, keep_r, keep_d});
        end
      end
      @(negedge clk);
      bit_en = 1'b1;
      px_stb = (c == 0);
      lanes_sel = (c == 0) ? sel : ~sel;          // R6: mid-pixel changes ignored
      drive_body((c == 0) ? b : ~b);             // R4: only strobe samples data
      @(posedge clk); #2;
      begin
        logic [2:0] exp = '0;
        for (int i = 0; i < 3; i++) begin
          int k = c * n + i;
          if (i < n && k < 30) begin
            exp[i] = prev_word[29 - k];
            rebuilt[29 - k] = lane_dat[i];
          end
        end
        check(lane_dat == exp, $sformatf("R1 R3 R6 R7 slot %0d lanes=%0d", c, n),
              {29'd0, lane_dat}, {29'd0, exp});
        check(px_ref == (c == 0), $sformatf("R5 ref slot %0d", c),
              {31'd0, px_ref}, {31'd0, c == 0});
      end
    end
    check(^rebuilt == 1'b0, "R2 parity of received word", {2'd0, rebuilt}, {2'd0, prev_word});
    prev_word = mkword(b);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(lane_dat == 3'b000 && px_ref == 1'b0, "R9 reset outputs", {28'd0, px_ref, lane_dat}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R9, R4: first transmitted word after reset is zero
    for (int v = 0; v < 8; v++)
      run_px(VEC[v][30:29], VEC[v][28:0], 0, -1);

    // R7: lanes low after word exhausted, for each lane count
    run_px(2'd1, 29'h1ABC_DEF1, 3, -1);
    run_px(2'd3, 29'h0555_5555, 2, -1);
    run_px(2'd2, 29'h1FFF_FFFF, 2, -1);
    // R8: stalls mid-pixel
    run_px(2'd3, 29'h0123_4567, 0, 4);
    run_px(2'd1, 29'h0000_0007, 0, 7);
    // R2: odd-weight and even-weight bodies
    run_px(2'd2, 29'h0000_0001, 0, -1);
    run_px(2'd1, 29'h0000_0003, 0, -1);
    run_px(2'd1, 29'h0, 0, -1);

    // R9: reset mid-pixel clears outputs and holding register
    @(negedge clk); rst_n = 1'b0; bit_en = 1'b0;
    @(posedge clk); #2;
    check(lane_dat == 3'b000 && px_ref == 1'b0, "R9 reset mid-run", {28'd0, px_ref, lane_dat}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    prev_word = '0;
    run_px(2'd3, 29'h1234_5678, 0, -1);
    run_px(2'd1, 29'h0, 0, -1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule